// File: doc/BRIEF.md
# Flash Completion Status Poller

This block sits on the host side of a parallel NOR flash bus. It waits for the flash to finish an internal program or erase, then tells the host it is done. A start pulse arms it when the host begins a command sequence. Along with the pulse it captures four things: the operation kind, the detection method, the true value of data bit 7 for a program, and a read budget. The poller then counts write-strobe rising edges reported by the command sequencer. The status bits only become meaningful after the final command write, so no read is issued before the 4th edge for a program or the 6th edge for an erase.

Once armed, the poller runs back-to-back read cycles. Each cycle is one read strobe pulse, answered by a returned-data valid pulse. The poller checks each answer in one of two ways. In complement-polling mode it looks at bit 7. In toggle mode it checks whether bit 6 has stopped alternating. On completion it raises a done flag. If the read budget runs out first, it raises a sticky error. Either way it stops reading. The flash is then ready for the host's next operation.

Top module: `fsp_poller`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done`, `err` and `rd_strobe` are all 0.
- R2: A `start` pulse seen while idle captures `op_erase`, `poll_toggle`, `expect_d7` and `read_limit`, and clears `done` and `err` on the following clock edge.
- R3: After an accepted start, no read is issued until the required number of `wr_rise` pulses has been counted: 4 when `op_erase`=0 (program) and 6 when `op_erase`=1 (erase). The first `rd_strobe` appears in the cycle right after the clock edge that sampled the last required `wr_rise`.
- R4: `rd_strobe` is a one-cycle pulse. A new strobe is not raised until the previous read has been answered by `rd_valid`.
- R5: In complement-polling mode (`poll_toggle`=0) during a program, a read completes the poll when `rd_data[7]` equals the captured `expect_d7`.
- R6: In complement-polling mode during an erase, a read completes the poll when `rd_data[7]` is 1. `expect_d7` has no effect.
- R7: In toggle mode (`poll_toggle`=1), a read completes the poll when its `rd_data[6]` equals bit 6 of the previous read of the same poll. The first read of a poll never completes it.
- R8: Let L be the captured `read_limit`, with 0 treated as 1. If the L-th read does not complete the poll, `err` is set and polling stops. A completion on the L-th read sets `done` instead. `done` and `err` are never both 1.
- R9: `done` and `err` hold their values, and no further `rd_strobe` is raised, until the next accepted start.
- R10: A `start` pulse that arrives while arming or polling is ignored. It does not change the edge target, the detection method, the read count or the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arm request, one-cycle pulse |
| op_erase | input | 1 | 1 = erase operation, 0 = program |
| poll_toggle | input | 1 | 1 = bit-6 toggle detection, 0 = bit-7 complement polling |
| expect_d7 | input | 1 | True value of bit 7 of the word being programmed |
| read_limit | input | CNT_W | Maximum number of status reads (0 acts as 1) |
| wr_rise | input | 1 | Pulse for each write-strobe rising edge on the flash bus |
| rd_strobe | output | 1 | Request one status read cycle |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | DATA_W | Status word from the flash |
| done | output | 1 | Operation completed (held) |
| err | output | 1 | Read budget exhausted before completion (sticky) |

## Verification
The assertions check the following on every cycle: the read strobe lasts one cycle; it falls silent once a result is posted; done and error are mutually exclusive; both flags stay put until a new start; the first read follows the arming edge at once; and each flag rises only after an answered read with the matching verdict. Other behaviour can only be shown by the bench's scenarios against a modelled flash. That includes the exact number of reads each detection method needs for a given busy time, the 4-versus-6 edge arming, the budget boundary where completion on the last allowed read wins, and the ignoring of late start pulses.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } fsp_state_e;

  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;

  // Completion verdict for one returned status read.
  function automatic logic poll_hit(input logic toggle_mode,
                                    input logic erase,
                                    input logic expect_b,
                                    input logic have_prev,
                                    input logic prev_b6,
                                    input logic cur_b7,
                                    input logic cur_b6);
    logic verdict;
    if (toggle_mode)
      verdict = have_prev && (prev_b6 == cur_b6);
    else if (erase)
      verdict = cur_b7;
    else
      verdict = (cur_b7 == expect_b);
    return verdict;
  endfunction

endpackage

// File: rtl/fsp_arm_counter.sv
module fsp_arm_counter #(
  parameter int unsigned PROG_EDGES  = 4,
  parameter int unsigned ERASE_EDGES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  input  logic erase,
  output logic arm_hit
);
  localparam int unsigned MAX_EDGES = (PROG_EDGES > ERASE_EDGES) ? PROG_EDGES : ERASE_EDGES;
  localparam int unsigned CW        = $clog2(MAX_EDGES + 1);
  localparam logic [CW-1:0] PROG_T  = CW'(PROG_EDGES);
  localparam logic [CW-1:0] ERASE_T = CW'(ERASE_EDGES);

  logic [CW-1:0] edge_cnt;
  logic [CW-1:0] target;

  assign target  = erase ? ERASE_T : PROG_T;
  assign arm_hit = count_en && (edge_cnt == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        edge_cnt <= '0;
    else if (clear)    edge_cnt <= '0;
    else if (count_en) edge_cnt <= edge_cnt + 1'b1;
  end
endmodule

// File: rtl/fsp_detect.sv
module fsp_detect #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              toggle_mode,
  input  logic              erase,
  input  logic              expect_b,
  input  logic [DATA_W-1:0] rd_data,
  output logic              hit
);
  import fsp_pkg::*;

  logic have_prev;
  logic prev_b6;

  assign hit = poll_hit(toggle_mode, erase, expect_b, have_prev, prev_b6,
                        rd_data[POLL_BIT], rd_data[TOGGLE_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
    end else if (clear) begin
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
    end else if (sample) begin
      have_prev <= 1'b1;
      prev_b6   <= rd_data[TOGGLE_BIT];
    end
  end
endmodule

// File: rtl/fsp_read_budget.sv
module fsp_read_budget #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic [CNT_W-1:0] limit,
  output logic             spent
);
  logic [CNT_W-1:0] reads_done;

  // True when the read being answered now uses up the budget.
  function automatic logic budget_spent(input logic [CNT_W-1:0] done_so_far,
                                        input logic [CNT_W-1:0] lim);
    logic [CNT_W:0] after;
    after = {1'b0, done_so_far} + 1'b1;
    return after >= {1'b0, lim};
  endfunction

  assign spent = budget_spent(reads_done, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reads_done <= '0;
    else if (clear)  reads_done <= '0;
    else if (sample) reads_done <= reads_done + 1'b1;
  end
endmodule

// File: rtl/fsp_poller.sv
module fsp_poller #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PROG_EDGES  = 4,
  parameter int unsigned ERASE_EDGES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic              poll_toggle,
  input  logic              expect_d7,
  input  logic [CNT_W-1:0]  read_limit,
  input  logic              wr_rise,
  output logic              rd_strobe,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err
);
  import fsp_pkg::*;

  fsp_state_e       state, state_nx;
  logic             erase_q, toggle_q, expect_q;
  logic [CNT_W-1:0] limit_q;
  logic             done_q, err_q;

  // Named internal events
  logic start_acc;
  logic edge_en;
  logic arm_hit;
  logic sample;
  logic hit;
  logic spent;
  logic finish_ok;
  logic finish_bad;

  assign start_acc  = (state == ST_IDLE) && start;
  assign edge_en    = (state == ST_ARM) && wr_rise;
  assign sample     = (state == ST_WAIT) && rd_valid;
  assign finish_ok  = sample && hit;
  assign finish_bad = sample && !hit && spent;

  fsp_arm_counter #(
    .PROG_EDGES (PROG_EDGES),
    .ERASE_EDGES(ERASE_EDGES)
  ) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_acc),
    .count_en(edge_en),
    .erase   (erase_q),
    .arm_hit (arm_hit)
  );

  fsp_detect #(.DATA_W(DATA_W)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc),
    .sample     (sample),
    .toggle_mode(toggle_q),
    .erase      (erase_q),
    .expect_b   (expect_q),
    .rd_data    (rd_data),
    .hit        (hit)
  );

  fsp_read_budget #(.CNT_W(CNT_W)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_acc),
    .sample(sample),
    .limit (limit_q),
    .spent (spent)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start_acc) state_nx = ST_ARM;
      ST_ARM:   if (arm_hit)   state_nx = ST_ISSUE;
      ST_ISSUE: state_nx = ST_WAIT;
      ST_WAIT:  if (sample)    state_nx = (hit || spent) ? ST_IDLE : ST_ISSUE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      erase_q  <= 1'b0;
      toggle_q <= 1'b0;
      expect_q <= 1'b0;
      limit_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_acc) begin
        erase_q  <= op_erase;
        toggle_q <= poll_toggle;
        expect_q <= expect_d7;
        limit_q  <= read_limit;
        done_q   <= 1'b0;
        err_q    <= 1'b0;
      end else begin
        if (finish_ok)  done_q <= 1'b1;
        if (finish_bad) err_q  <= 1'b1;
      end
    end
  end

  assign rd_strobe = (state == ST_ISSUE);
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/fsp_poller_chk.sv
module fsp_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic start_acc,
  input logic arm_hit,
  input logic sample,
  input logic hit,
  input logic rd_strobe,
  input logic done,
  input logic err
);
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);

  assert_quiet_when_finished_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !rd_strobe);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start_acc) |=> err);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_acc) |=> done);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (!done && !err));

  assert_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_hit |=> rd_strobe);

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(sample && hit));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(sample && !hit));
endmodule

bind fsp_poller fsp_poller_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_acc(start_acc),
  .arm_hit  (arm_hit),
  .sample   (sample),
  .hit      (hit),
  .rd_strobe(rd_strobe),
  .done     (done),
  .err      (err)
);

// File: tb/fsp_poller_bench.sv
module fsp_poller_bench;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              op_erase = 1'b0;
  logic              poll_toggle = 1'b0;
  logic              expect_d7 = 1'b0;
  logic [CNT_W-1:0]  read_limit = '0;
  logic              wr_rise = 1'b0;
  logic              rd_strobe;
  logic              rd_valid = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;
  logic              done, err;

  int n_checks = 0;
  int n_fails  = 0;
  int strobes  = 0;
  bit back_to_back = 0;
  bit prev_strobe  = 0;

  // Flash status model
  int   m_busy  = 0;
  logic m_tog   = 1'b0;
  logic m_erase = 1'b0;
  logic m_true7 = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  fsp_poller #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsp_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .poll_toggle(poll_toggle), .expect_d7(expect_d7), .read_limit(read_limit),
    .wr_rise(wr_rise), .rd_strobe(rd_strobe), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] model_read();
    logic [DATA_W-1:0] w;
    w = 16'h1A25;
    if (m_busy > 0) begin
      m_busy--;
      w[6] = m_tog;
      m_tog = ~m_tog;
      w[7] = m_erase ? 1'b0 : ~m_true7;
    end else begin
      w[6] = m_tog;
      w[7] = m_erase ? 1'b1 : m_true7;
    end
    return w;
  endfunction

  // Read responder: answers each strobe one cycle later for one cycle.
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_strobe) begin
        @(negedge clk);
        rd_data  = model_read();
        rd_valid = 1'b1;
      end
    end
  end

  // Strobe monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_strobe) strobes++;
      if (rd_strobe && prev_strobe) back_to_back = 1;
      prev_strobe = rd_strobe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  // One complete poll: arm, count edges, wait for the outcome, check it.
  task automatic run_poll(input string req, input logic er, input logic tg,
                          input logic e7, input int busy, input int lim,
                          input int inj_arm, input int inj_read);
    int  target, need, eff, exp_n, cyc;
    bit  exp_done, injected;
    target = er ? 6 : 4;
    need   = tg ? busy + 2 : busy + 1;
    eff    = (lim == 0) ? 1 : lim;
    exp_done = (need <= eff);
    exp_n    = exp_done ? need : eff;
    m_busy = busy; m_tog = 1'b0; m_erase = er; m_true7 = e7;
    back_to_back = 0;
    @(negedge clk);
    strobes = 0;
    op_erase = er; poll_toggle = tg; expect_d7 = e7; read_limit = CNT_W'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && !err, "R2", {req, " flags cleared by start"}, {done, err}, 0);
    for (int e = 1; e <= target; e++) begin
      @(negedge clk) wr_rise = 1'b1;
      @(negedge clk) wr_rise = 1'b0;
      if (e < target)
        check(!rd_strobe && strobes == 0, "R3", {req, " no read while arming"}, strobes, 0);
      else
        check(rd_strobe == 1'b1, "R3", {req, " first read after last edge"}, rd_strobe, 1);
      if (e == inj_arm) begin
        @(negedge clk) begin start = 1'b1; op_erase = ~er; end
        @(negedge clk) begin start = 1'b0; op_erase = er; end
      end
    end
    cyc = 0; injected = 0;
    while (!(done || err) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (start) begin
        start = 1'b0; op_erase = er; poll_toggle = tg;
      end else if (inj_read > 0 && !injected && strobes == inj_read && !done && !err) begin
        start = 1'b1; op_erase = ~er; poll_toggle = ~tg; injected = 1;
      end
    end
    start = 1'b0; op_erase = er; poll_toggle = tg;
    check(cyc < 3000, req, {req, " poll finished"}, cyc, 0);
    check(done == exp_done, req, {req, " done flag"}, done, exp_done);
    check(err == !exp_done, exp_done ? req : "R8", {req, " err flag"}, err, !exp_done);
    check(strobes == exp_n, req, {req, " read count"}, strobes, exp_n);
    check(!back_to_back, "R4", {req, " strobe single cycle"}, back_to_back, 0);
    repeat (12) @(negedge clk);
    check(strobes == exp_n, "R9", {req, " no reads after result"}, strobes, exp_n);
    check(done == exp_done && err == !exp_done, "R9", {req, " flags held"}, {done, err},
          {exp_done, !exp_done});
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(!done && !err && !rd_strobe, "R1", "outputs in reset", {done, err, rd_strobe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !err && !rd_strobe, "R1", "outputs after reset", {done, err, rd_strobe}, 0);
  endtask

  initial begin
    test_reset();
    run_poll("R5", 1'b0, 1'b0, 1'b1, 3, 50, 0, 0);   // program, bit 7 polling, true bit 1
    run_poll("R5", 1'b0, 1'b0, 1'b0, 0, 50, 0, 0);   // program already finished, true bit 0
    run_poll("R6", 1'b1, 1'b0, 1'b0, 5, 50, 0, 0);   // erase, expect bit ignored
    run_poll("R6", 1'b1, 1'b0, 1'b1, 2, 50, 0, 0);
    run_poll("R7", 1'b0, 1'b1, 1'b1, 2, 50, 0, 0);   // toggle, program
    run_poll("R7", 1'b1, 1'b1, 1'b0, 0, 50, 0, 0);   // toggle, first read never completes
    run_poll("R8", 1'b0, 1'b0, 1'b1, 10, 4, 0, 0);   // budget exhausted
    run_poll("R8", 1'b0, 1'b0, 1'b1, 3, 4, 0, 0);    // completion on last allowed read
    run_poll("R8", 1'b0, 1'b1, 1'b0, 0, 0, 0, 0);    // limit 0 acts as 1
    run_poll("R10", 1'b0, 1'b0, 1'b1, 3, 20, 0, 2);  // start during reads ignored
    run_poll("R10", 1'b0, 1'b0, 1'b0, 1, 20, 2, 0);  // start during arming ignored
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule